// File: doc/BRIEF.md
# Serial Flash Page-Size Configuration Unit

This block sits inside the model of an SPI-slave serial memory and handles the one command that switches the array page size from 264 bytes to 256 bytes. It watches chip select, the serial clock and the serial data input, and brings them into the system clock domain. It compares the first 32 bits shifted in after chip select falls against a fixed four-byte key. If the key matches and chip select rises exactly on the 32nd bit, it starts a self-timed program cycle. During that cycle a status register shows the device as not ready. At the end of the cycle a one-time-programmable configuration bit is set.

The configuration bit reads back at once through status bit 0. The page size the array actually uses comes from a separate active bit. That bit loads from the configuration bit only when the block comes out of power-on reset (`rst_ni`), so the new size appears only after a power cycle. A separate `otp_clear_ni` input returns the configuration bit to its factory-blank state, for simulation only. If power is lost during the program cycle, the configuration bit stays clear.

Top module: `page_cfg_unit`

## Requirements
- R1: After factory clear and power-on reset, `page_size_o` is 264, status bit 0 (configured) is 0 and status bit 7 (ready) is 1. All other status bits are always 0.
- R2: The serial input is sampled on the rising edge of `sck_i` while `cs_ni` is low, most significant bit first. A command whose first four bytes are 0x3D, 0x2A, 0x80, 0xA6, and which ends with `cs_ni` rising after exactly 32 bits, starts a program cycle. Status bit 7 goes to 0 within a few clock cycles of that rise.
- R3: A command is discarded if chip select rises after any bit count other than 32, or if any byte differs from the key. A discarded command does not clear status bit 7 and does not change status bit 0.
- R4: A program cycle keeps status bit 7 at 0 for exactly BUSY_CYCLES clock cycles. At its end status bit 0 becomes 1.
- R5: `page_size_o` does not change when programming completes. It changes to 256 only after the next power-on reset.
- R6: If `rst_ni` is asserted during a program cycle, the configuration bit stays 0 and, after reset, the page size stays 264.
- R7: A command whose chip-select rise falls within a program cycle is ignored. The cycle is neither restarted nor extended.
- R8: Once status bit 0 is 1, a valid key does not start a new cycle. Only `otp_clear_ni` clears the bit, and the page size stays 256 across later power cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset (models a power cycle) |
| otp_clear_ni | input | 1 | Active-low asynchronous return of the configuration bit to factory-blank state |
| cs_ni | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI serial clock, mode 0 |
| si_i | input | 1 | SPI serial data input |
| status_o | output | 8 | Status: bit 7 ready, bit 0 configured for 256-byte pages, others 0 |
| page_size_o | output | 10 | Page size in use by the array: 264 or 256 |

## Verification
The hardest states to reach are the ones that overlap a program cycle. The bench cuts power partway through a cycle and checks that the configuration bit stays clear. It also finishes a second valid key while the first cycle is still running. Both cases need the bench's busy interval to be longer than one full 32-bit command. The bench therefore raises BUSY_CYCLES and times the second command from a known start. Random words with random bit counts are mixed with the exact key and with single-bit corruptions of it. This exercises both the byte comparison and the exact-count rule at 31, 32 and 33 bits.

// File: rtl/page_cfg_pkg.sv
package page_cfg_pkg;
  localparam int unsigned KEY_BYTES = 4;
  localparam int unsigned KEY_BITS  = KEY_BYTES * 8;
  localparam int unsigned CNT_W     = $clog2(KEY_BITS + 2);
  // key byte 0 is shifted in first
  localparam logic [KEY_BYTES-1:0][7:0] KEY = {8'hA6, 8'h80, 8'h2A, 8'h3D};
  localparam int unsigned STS_READY = 7;
  localparam int unsigned STS_CFG   = 0;
  localparam logic [9:0] PAGE_STD = 10'd264;
  localparam logic [9:0] PAGE_BIN = 10'd256;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic cs_act_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sck_rise_o,
  output logic si_o
);
  localparam int unsigned STAGES = 2;
  // lanes: 0 cs, 1 sck, 2 si
  localparam logic [2:0] IDLE = 3'b001;

  logic [STAGES-1:0][2:0] sync_q;
  logic [2:0]             prev_q;
  logic [2:0]             cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{IDLE}};
      prev_q <= IDLE;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], {si_i, sck_i, cs_ni}};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign cur        = sync_q[STAGES-1];
  assign cs_act_o   = ~cur[0];
  assign cs_fall_o  = prev_q[0] & ~cur[0];
  assign cs_rise_o  = ~prev_q[0] & cur[0];
  assign sck_rise_o = ~prev_q[1] & cur[1];
  assign si_o       = cur[2];
endmodule

// File: rtl/key_matcher.sv
module key_matcher
  import page_cfg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_act_i,
  input  logic cs_fall_i,
  input  logic sck_rise_i,
  input  logic si_i,
  output logic key_ok_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(KEY_BITS);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(KEY_BITS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       shift_q;
  logic             miss_q;
  logic [7:0]       shift_d;

  assign shift_d = {shift_q[6:0], si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= '0;
      miss_q  <= 1'b0;
    end else if (cs_fall_i) begin
      cnt_q   <= '0;
      shift_q <= '0;
      miss_q  <= 1'b0;
    end else if (cs_act_i && sck_rise_i) begin
      shift_q <= shift_d;
      if (cnt_q != OVER) cnt_q <= cnt_q + 1'b1;
      if (cnt_q < FULL && cnt_q[2:0] == 3'd7 &&
          shift_d != KEY[cnt_q[CNT_W-1:3]])
        miss_q <= 1'b1;
    end
  end

  assign key_ok_o = (cnt_q == FULL) && !miss_q;

  // R3
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= OVER);
  // R3
  miss_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_q && !cs_fall_i) |=> miss_q);
endmodule

// File: rtl/otp_cfg.sv
module otp_cfg
  import page_cfg_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic otp_clear_ni,
  input  logic cs_rise_i,
  input  logic key_ok_i,
  output logic busy_o,
  output logic otp_o,
  output logic active_o
);
  localparam int unsigned BW = $clog2(BUSY_CYCLES + 1);

  logic [BW-1:0] cnt_q;
  logic          busy_q;
  logic          otp_q;
  logic          active_q;
  logic          loaded_q;
  logic          start;
  logic          done;

  assign start = cs_rise_i && key_ok_i && !busy_q && !otp_q;
  assign done  = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= BW'(BUSY_CYCLES - 1);
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // nonvolatile bit: survives rst_ni
  always_ff @(posedge clk_i or negedge otp_clear_ni) begin
    if (!otp_clear_ni) otp_q <= 1'b0;
    else if (done && rst_ni) otp_q <= 1'b1;
  end

  // active page size latched once after power-up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      active_q <= 1'b0;
    end else if (!loaded_q) begin
      loaded_q <= 1'b1;
      active_q <= otp_q;
    end
  end

  assign busy_o   = busy_q;
  assign otp_o    = otp_q;
  assign active_o = active_q;

  // R2
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(cs_rise_i && key_ok_i));
  // R8
  otp_hold_chk: assert property (@(posedge clk_i) disable iff (!otp_clear_ni)
    otp_q |=> otp_q);
  // R5
  active_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |=> $stable(active_q));
  // R4
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !otp_clear_ni)
    $fell(busy_q) |-> otp_q);
  // R8
  no_reprog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !otp_q);
endmodule

// File: rtl/page_cfg_unit.sv
module page_cfg_unit
  import page_cfg_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       otp_clear_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       si_i,
  output logic [7:0] status_o,
  output logic [9:0] page_size_o
);
  logic cs_act, cs_fall, cs_rise, sck_rise, si_s;
  logic key_ok, busy, otp, active;

  spi_edge_sync u_sync (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .si_i,
    .cs_act_o(cs_act), .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
    .sck_rise_o(sck_rise), .si_o(si_s)
  );

  key_matcher u_match (
    .clk_i, .rst_ni, .cs_act_i(cs_act), .cs_fall_i(cs_fall),
    .sck_rise_i(sck_rise), .si_i(si_s), .key_ok_o(key_ok)
  );

  otp_cfg #(.BUSY_CYCLES(BUSY_CYCLES)) u_otp (
    .clk_i, .rst_ni, .otp_clear_ni, .cs_rise_i(cs_rise), .key_ok_i(key_ok),
    .busy_o(busy), .otp_o(otp), .active_o(active)
  );

  always_comb begin
    status_o            = '0;
    status_o[STS_READY] = ~busy;
    status_o[STS_CFG]   = otp;
  end

  assign page_size_o = active ? PAGE_BIN : PAGE_STD;

  // R1
  status_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6:1] == '0);
endmodule

// File: tb/page_cfg_unit_bench.sv
module page_cfg_unit_bench;
  localparam int unsigned BUSY = 400;
  localparam logic [31:0] KEYW = 32'h3D2A_80A6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       otp_clear_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic       sck_i = 1'b0;
  logic       si_i = 1'b0;
  logic [7:0] status_o;
  logic [9:0] page_size_o;

  int checks = 0;
  int errors = 0;
  bit m_otp = 1'b0;
  bit m_act = 1'b0;

  page_cfg_unit #(.BUSY_CYCLES(BUSY)) u_page_cfg_unit (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  function automatic bit accept(input logic [31:0] w, input int nbits, input bit otp);
    return nbits == 32 && w == KEYW && !otp;
  endfunction

  function automatic int exp_page(input bit act);
    return act ? 256 : 264;
  endfunction

  // bits taken MSB-first from the top of a 48-bit field
  task automatic send(input logic [47:0] w, input int nbits);
    cs_ni = 1'b0; clks(4);
    for (int i = 0; i < nbits; i++) begin
      si_i = w[47-i]; clks(4);
      sck_i = 1'b1;   clks(4);
      sck_i = 1'b0;
    end
    clks(4);
    cs_ni = 1'b1;
  endtask

  task automatic power_cycle(input bit factory);
    rst_ni = 1'b0;
    if (factory) otp_clear_ni = 1'b0;
    clks(3);
    rst_ni = 1'b1; otp_clear_ni = 1'b1;
    clks(3);
    if (factory) m_otp = 1'b0;
    m_act = m_otp;
  endtask

  task automatic wait_ready;
    for (int i = 0; i < BUSY + 50 && status_o[7] == 1'b0; i++) clks(1);
  endtask

  initial begin
    clks(2000000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int busy_len;
    void'($urandom(32'd1234));
    clks(3);
    power_cycle(1'b1);
    // R1
    check("R1 page", page_size_o, 264);
    check("R1 cfg", status_o[0], 0);
    check("R1 ready", status_o[7], 1);
    check("R1 rsvd", status_o[6:1], 0);

    // R3 short, long, corrupted
    send({KEYW[31:1], 16'h0}, 31); clks(8);
    check("R3 31 bits", status_o[7], 1);
    send({KEYW, 1'b1, 15'h0}, 33); clks(8);
    check("R3 33 bits", status_o[7], 1);
    send({KEYW ^ 32'h0001_0000, 16'h0}, 32); clks(8);
    check("R3 bad byte", status_o[7], 1);
    check("R3 cfg", status_o[0], 0);

    // R2 / R4 exact busy length
    send({KEYW, 16'h0}, 32);
    busy_len = 0;
    clks(1);
    for (int i = 0; i < 8 && status_o[7] == 1'b1; i++) clks(1);
    check("R2 busy", status_o[7], 0);
    for (int i = 0; i < BUSY + 50 && status_o[7] == 1'b0; i++) begin
      busy_len++; clks(1);
    end
    check("R4 length", busy_len, BUSY);
    check("R4 cfg", status_o[0], 1);
    m_otp = 1'b1;
    // R5
    check("R5 no change yet", page_size_o, 264);
    power_cycle(1'b0);
    check("R5 after power", page_size_o, 256);

    // R8 reissue ignored, survives power cycles
    send({KEYW, 16'h0}, 32); clks(8);
    check("R8 no busy", status_o[7], 1);
    power_cycle(1'b0);
    check("R8 page", page_size_o, 256);
    check("R8 cfg", status_o[0], 1);

    // R6 power loss mid-cycle
    power_cycle(1'b1);
    send({KEYW, 16'h0}, 32); clks(20);
    check("R6 busy", status_o[7], 0);
    power_cycle(1'b0);
    clks(BUSY + 20);
    check("R6 cfg", status_o[0], 0);
    check("R6 page", page_size_o, 264);

    // R7 second key during busy
    send({KEYW, 16'h0}, 32); clks(8);
    busy_len = 8;
    send({KEYW, 16'h0}, 32);
    busy_len += 32 * 8 + 8;
    clks(BUSY - busy_len + 10);
    check("R7 not extended", status_o[7], 1);
    check("R7 cfg", status_o[0], 1);
    m_otp = 1'b1;
    power_cycle(1'b1);

    // random mix
    for (int it = 0; it < 30; it++) begin
      logic [31:0] w;
      int nb;
      bit acc;
      int r;
      r = $urandom_range(0, 7);
      w = $urandom();
      nb = $urandom_range(29, 35);
      if (r < 2) begin w = KEYW; nb = 32; end
      else if (r == 2) begin w = KEYW ^ (32'h1 << $urandom_range(0, 31)); nb = 32; end
      else if (r == 3) begin w = KEYW; end
      acc = accept(w, nb, m_otp);
      send({w, 16'h0}, nb); clks(8);
      check(acc ? "R2 rand" : "R3 rand", status_o[7], acc ? 0 : 1);
      wait_ready();
      if (acc) m_otp = 1'b1;
      check("R4 rand cfg", status_o[0], int'(m_otp));
      check("R5 rand page", page_size_o, exp_page(m_act));
      if ($urandom_range(0, 3) == 0) begin
        power_cycle($urandom_range(0, 1) == 1);
        check("R5 rand power", page_size_o, exp_page(m_act));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule